// File: doc/BRIEF.md
# Sector Hamming ECC Checker

This block computes a single-error-correcting Hamming code over a 512-byte flash sector that is streamed through it one byte per accepted cycle. The same parity pass serves both directions. When a sector is written, the host takes the computed code and stores it in the spare area. When a sector is read back, the host presents the stored code, and the block classifies the sector. The four outcomes are: clean; one flipped data bit, with its byte offset and bit index; a hit in the code bytes themselves; or damage that cannot be repaired. Flipping the reported bit in the page buffer is left to the host.

A page holds `PAGE_SECTORS` sectors that are processed one after another, each against its own code. For every result the block reports which sector of the page it belongs to and where that sector's code lives in the spare area. A sector that was never programmed reads as all ones in both data and spare. Such a sector is accepted as clean instead of being flagged.

Top module: `hecc_sector_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `res_vld` is 0 and `res_status`, `err_byte`, `err_bit` and `calc_code` are all 0.
- R2: The code has 24 bits made of 12 even/odd pairs, with pair i at bits 2i (even half) and 2i+1 (odd half).
  - Pairs 0, 1 and 2 are column parities. Data bit b belongs to the odd half of pair j when bit j of b is 1.
  - Pairs 3 to 11 are row parities. The parity of the byte at sector address A is folded into the odd half of pair 3+k when A[k] is 1, and into the even half otherwise.
  - `calc_code` shows this code for the completed sector.
- R3: `res_vld` rises in the cycle after the 512th byte is accepted. It stays high with all result outputs unchanged until `sec_start` is pulsed. It is low in the cycle after a `sec_start` pulse.
- R4: If the stored code equals the computed code, `res_status` is 00 (clean).
- R5: If exactly 12 bits of the syndrome (stored XOR computed) are set, `res_status` is 01.
  - `err_byte` is formed from syndrome bits 23,21,...,7 (most significant first).
  - `err_bit` is formed from syndrome bits 5,3,1.
- R6: If exactly one syndrome bit is set, `res_status` is 10 (code bytes hit).
- R7: Any other non-zero syndrome gives `res_status` 11. `err_byte` and `err_bit` are 0 whenever the status is not 01.
- R8: A stored code of all ones together with a computed code of all zeros gives `res_status` 00.
- R9: Completed sectors are numbered 0 to PAGE_SECTORS-1 in order on `res_idx`, wrapping to 0 after the last one. `res_ofs` is 8+16*`res_idx` (the spare-area byte offset of that sector's code).
- R10: A byte accepted in the same cycle as `sec_start` is byte 0 of the new sector. A sector interrupted by `sec_start` is discarded and does not advance `res_idx`.
- R11: Bytes offered after the 512th one and before the next `sec_start` are ignored. The result outputs do not change.
- R12: Cycles with `in_vld` low do not advance the byte address or the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_start | input | 1 | Pulse: clear parity and byte address, drop the held result |
| in_vld | input | 1 | A data byte is present on `in_byte` |
| in_byte | input | 8 | Sector data byte |
| st_code | input | 24 | Code read from the spare area, sampled with the 512th byte |
| res_vld | output | 1 | Result for the finished sector is valid and held |
| res_status | output | 2 | 00 clean, 01 fixable data bit, 10 code hit, 11 uncorrectable |
| err_byte | output | 9 | Byte offset of the fixable bit |
| err_bit | output | 3 | Bit index of the fixable bit |
| calc_code | output | 24 | Code computed over the finished sector |
| res_idx | output | 2 | Sector number within the page |
| res_ofs | output | 7 | Spare-area offset of that sector's code |

## Verification
Two pairs of events can fall in the same cycle:
- Clearing the accumulators for a new sector and folding in that sector's first byte both happen when `sec_start` and `in_vld` are high together.
- A new `sec_start` can also arrive while a previous result is still held, and it must drop that result.

The bench provokes both: it sends sectors whose first byte rides on the start pulse, and it aborts a half-streamed sector with a fresh start. A behavioural model that treats the pulse as "reset then accept" is compared with every output on every clock. In addition, the final result is checked against a code computed directly from the sector buffer.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    // Outcome of comparing the stored code with the computed one.
    typedef enum logic [1:0] {
        ST_CLEAN    = 2'b00,
        ST_FIXABLE  = 2'b01,
        ST_CODE_HIT = 2'b10,
        ST_FATAL    = 2'b11
    } ecc_status_e;

    // Column parity pairs cover bit positions 0..7 of a byte.
    localparam int COL_PAIRS = 3;

endpackage

// File: rtl/hecc_byte_par.sv
// Column contributions and row parity of one data byte.
// col[2j] collects bits whose index has bit j clear, col[2j+1] those with it set.
module hecc_byte_par (
    input  logic [7:0] data_i,
    output logic [5:0] col_o,
    output logic       row_o
);
    always_comb begin
        col_o = '0;
        for (int b = 0; b < 8; b++) begin
            for (int j = 0; j < hecc_pkg::COL_PAIRS; j++) begin
                if (((b >> j) & 1) != 0) begin
                    col_o[2*j+1] = col_o[2*j+1] ^ data_i[b];
                end else begin
                    col_o[2*j] = col_o[2*j] ^ data_i[b];
                end
            end
        end
        row_o = ^data_i;
    end
endmodule

// File: rtl/hecc_classify.sv
// Turns a stored and a computed code into a status plus error location.
module hecc_classify #(
    parameter  int AW = 9,
    localparam int CW = 2 * (hecc_pkg::COL_PAIRS + AW),
    localparam int PW = $clog2(CW + 1)
) (
    input  logic [CW-1:0]           stored_i,
    input  logic [CW-1:0]           calc_i,
    output hecc_pkg::ecc_status_e   status_o,
    output logic [AW-1:0]           byte_o,
    output logic [2:0]              bit_o
);
    import hecc_pkg::*;

    logic [CW-1:0] syn;
    logic [PW-1:0] pop;
    logic          erased;
    logic [AW-1:0] off;
    logic [2:0]    bidx;

    always_comb begin
        syn    = stored_i ^ calc_i;
        pop    = '0;
        for (int i = 0; i < CW; i++) begin
            pop = pop + PW'(syn[i]);
        end
        erased = (&stored_i) && !(|calc_i);
        for (int k = 0; k < AW; k++) begin
            off[k] = syn[2*k + 2*COL_PAIRS + 1];
        end
        for (int j = 0; j < COL_PAIRS; j++) begin
            bidx[j] = syn[2*j + 1];
        end

        byte_o = '0;
        bit_o  = '0;
        if (syn == '0 || erased) begin
            status_o = ST_CLEAN;
        end else if (pop == PW'(CW / 2)) begin
            status_o = ST_FIXABLE;
            byte_o   = off;
            bit_o    = bidx;
        end else if (pop == PW'(1)) begin
            status_o = ST_CODE_HIT;
        end else begin
            status_o = ST_FATAL;
        end
    end
endmodule

// File: rtl/hecc_spare_map.sv
// Spare-area byte offset of a sector's code inside its page.
module hecc_spare_map #(
    parameter int PAGE_SECTORS = 4,
    parameter int SPARE_BASE   = 8,
    parameter int SPARE_STRIDE = 16,
    parameter int IW           = 2,
    parameter int OW           = 7
) (
    input  logic [IW-1:0] idx_i,
    output logic [OW-1:0] ofs_o
);
    generate
        if (PAGE_SECTORS > 1) begin : g_multi
            assign ofs_o = OW'(SPARE_BASE) + OW'(SPARE_STRIDE) * OW'(idx_i);
        end else begin : g_single
            logic unused_idx;
            assign unused_idx = ^idx_i;
            assign ofs_o      = '0;
        end
    endgenerate
endmodule

// File: rtl/hecc_sector_unit.sv
// Streaming Hamming ECC over one sector, one byte per accepted cycle.
module hecc_sector_unit #(
    parameter  int SECTOR_BYTES = 512,
    parameter  int PAGE_SECTORS = 4,
    parameter  int SPARE_BASE   = 8,
    parameter  int SPARE_STRIDE = 16,
    localparam int AW = $clog2(SECTOR_BYTES),
    localparam int CW = 2 * (hecc_pkg::COL_PAIRS + AW),
    localparam int IW = (PAGE_SECTORS > 1) ? $clog2(PAGE_SECTORS) : 1,
    localparam int OW = $clog2(SPARE_BASE + SPARE_STRIDE * PAGE_SECTORS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_start,
    input  logic          in_vld,
    input  logic [7:0]    in_byte,
    input  logic [CW-1:0] st_code,
    output logic          res_vld,
    output logic [1:0]    res_status,
    output logic [AW-1:0] err_byte,
    output logic [2:0]    err_bit,
    output logic [CW-1:0] calc_code,
    output logic [IW-1:0] res_idx,
    output logic [OW-1:0] res_ofs
);
    import hecc_pkg::*;

    localparam int ROW_BASE = 2 * COL_PAIRS;

    typedef struct packed {
        logic [CW-1:0] acc;
        logic [AW:0]   cnt;
        logic          vld;
        ecc_status_e   st;
        logic [AW-1:0] eb;
        logic [2:0]    ebit;
        logic [CW-1:0] code;
        logic [IW-1:0] ridx;
        logic [IW-1:0] nidx;
    } state_t;

    state_t q, d;

    logic [5:0]    col;
    logic          rowp;
    logic [CW-1:0] base_acc;
    logic [AW:0]   base_cnt;
    logic [AW-1:0] addr;
    logic [CW-1:0] acc_upd;
    logic          take;
    logic          last;
    ecc_status_e   cls_st;
    logic [AW-1:0] cls_byte;
    logic [2:0]    cls_bit;

    hecc_byte_par u_par (
        .data_i (in_byte),
        .col_o  (col),
        .row_o  (rowp)
    );

    hecc_classify #(.AW(AW)) u_cls (
        .stored_i (st_code),
        .calc_i   (acc_upd),
        .status_o (cls_st),
        .byte_o   (cls_byte),
        .bit_o    (cls_bit)
    );

    hecc_spare_map #(
        .PAGE_SECTORS (PAGE_SECTORS),
        .SPARE_BASE   (SPARE_BASE),
        .SPARE_STRIDE (SPARE_STRIDE),
        .IW           (IW),
        .OW           (OW)
    ) u_map (
        .idx_i (q.ridx),
        .ofs_o (res_ofs)
    );

    always_comb begin
        // A start pulse acts first, so a byte in the same cycle lands at address 0.
        base_acc = sec_start ? '0 : q.acc;
        base_cnt = sec_start ? '0 : q.cnt;
        addr     = base_cnt[AW-1:0];
        take     = in_vld && !base_cnt[AW];
        last     = take && (addr == {AW{1'b1}});

        acc_upd        = base_acc;
        acc_upd[5:0]   = base_acc[5:0] ^ col;
        for (int k = 0; k < AW; k++) begin
            if (addr[k]) begin
                acc_upd[ROW_BASE + 2*k + 1] = base_acc[ROW_BASE + 2*k + 1] ^ rowp;
            end else begin
                acc_upd[ROW_BASE + 2*k] = base_acc[ROW_BASE + 2*k] ^ rowp;
            end
        end

        d     = q;
        d.acc = base_acc;
        d.cnt = base_cnt;
        if (sec_start) begin
            d.vld  = 1'b0;
            d.st   = ST_CLEAN;
            d.eb   = '0;
            d.ebit = '0;
            d.code = '0;
        end
        if (take) begin
            d.acc = acc_upd;
            d.cnt = base_cnt + 1'b1;
        end
        if (last) begin
            d.vld  = 1'b1;
            d.st   = cls_st;
            d.eb   = cls_byte;
            d.ebit = cls_bit;
            d.code = acc_upd;
            d.ridx = q.nidx;
            if (q.nidx == IW'(PAGE_SECTORS - 1)) begin
                d.nidx = '0;
            end else begin
                d.nidx = q.nidx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{acc: '0, cnt: '0, vld: 1'b0, st: ST_CLEAN, eb: '0,
                   ebit: '0, code: '0, ridx: '0, nidx: '0};
        end else begin
            q <= d;
        end
    end

    assign res_vld    = q.vld;
    assign res_status = q.st;
    assign err_byte   = q.eb;
    assign err_bit    = q.ebit;
    assign calc_code  = q.code;
    assign res_idx    = q.ridx;

endmodule

// File: rtl/hecc_sva.sv
// Protocol properties of the sector unit; keeps its own byte counter.
module hecc_sva #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_start,
    input logic          in_vld,
    input logic          res_vld,
    input logic [1:0]    res_status,
    input logic [AW-1:0] err_byte,
    input logic [2:0]    err_bit
);
    logic [AW:0] seen_q;
    logic [AW:0] seen_base;
    logic        last_byte;

    assign seen_base = sec_start ? '0 : seen_q;
    assign last_byte = in_vld && (seen_base == (AW+1)'((1 << AW) - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (in_vld && !seen_base[AW]) begin
            seen_q <= seen_base + 1'b1;
        end else begin
            seen_q <= seen_base;
        end
    end

    a_r3_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |=> res_vld);

    a_r3_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !sec_start) |=> (res_vld && $stable(res_status)
                                     && $stable(err_byte) && $stable(err_bit)));

    a_r3_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
        sec_start |=> !res_vld);

    a_r7_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_status != 2'b01) |-> (err_byte == '0 && err_bit == '0));

    a_r12_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_vld && !last_byte) |=> !res_vld);

endmodule

bind hecc_sector_unit hecc_sva #(.AW(AW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_start  (sec_start),
    .in_vld     (in_vld),
    .res_vld    (res_vld),
    .res_status (res_status),
    .err_byte   (err_byte),
    .err_bit    (err_bit)
);

// File: tb/tb_hecc_sector_unit.sv
`timescale 1ns/1ps
module tb_hecc_sector_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_start = 1'b0;
    logic        in_vld = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [23:0] st_code = '0;
    logic        res_vld;
    logic [1:0]  res_status;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;
    logic [23:0] calc_code;
    logic [1:0]  res_idx;
    logic [6:0]  res_ofs;

    always #2 clk = ~clk;

    hecc_sector_unit dut (
        .clk(clk), .rst_n(rst_n), .sec_start(sec_start), .in_vld(in_vld),
        .in_byte(in_byte), .st_code(st_code), .res_vld(res_vld),
        .res_status(res_status), .err_byte(err_byte), .err_bit(err_bit),
        .calc_code(calc_code), .res_idx(res_idx), .res_ofs(res_ofs)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    logic [7:0] dbuf [512];
    int    exp_idx = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Behavioural code definition: each set bit toggles one half of every pair.
    function automatic logic [23:0] code_of_buf();
        logic [23:0] c;
        c = '0;
        for (int a = 0; a < 512; a++)
            for (int b = 0; b < 8; b++)
                if (dbuf[a][b]) begin
                    for (int j = 0; j < 3; j++) c[2*j + ((b >> j) & 1)] ^= 1'b1;
                    for (int k = 0; k < 9; k++) c[6 + 2*k + ((a >> k) & 1)] ^= 1'b1;
                end
        return c;
    endfunction

    task automatic classify(input logic [23:0] s, input logic [23:0] c,
                            output int st, output int eb, output int ebt);
        logic [23:0] y;
        int n;
        y = s ^ c; n = 0; eb = 0; ebt = 0;
        for (int i = 0; i < 24; i++) n += int'(y[i]);
        if (y == 0 || (s == 24'hFFFFFF && c == 0)) st = 0;
        else if (n == 12) begin
            st = 1;
            for (int k = 0; k < 9; k++) eb |= int'(y[7 + 2*k]) << k;
            ebt = int'(y[1]) | (int'(y[3]) << 1) | (int'(y[5]) << 2);
        end else if (n == 1) st = 2;
        else st = 3;
    endtask

    // Cycle model updated on every edge.
    int m_cnt, m_st, m_eb, m_ebit, m_ridx, m_nidx;
    logic [23:0] m_acc, m_code;
    bit m_vld;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_acc = 0; m_vld = 0; m_st = 0; m_eb = 0; m_ebit = 0;
            m_code = 0; m_ridx = 0; m_nidx = 0;
        end else begin
            if (sec_start) begin
                m_cnt = 0; m_acc = 0; m_vld = 0; m_st = 0; m_eb = 0; m_ebit = 0; m_code = 0;
            end
            if (in_vld && m_cnt < 512) begin
                for (int b = 0; b < 8; b++)
                    if (in_byte[b]) begin
                        for (int j = 0; j < 3; j++) m_acc[2*j + ((b >> j) & 1)] ^= 1'b1;
                        for (int k = 0; k < 9; k++) m_acc[6 + 2*k + ((m_cnt >> k) & 1)] ^= 1'b1;
                    end
                m_cnt++;
                if (m_cnt == 512) begin
                    classify(st_code, m_acc, m_st, m_eb, m_ebit);
                    m_vld = 1; m_code = m_acc; m_ridx = m_nidx; m_nidx = (m_nidx + 1) % 4;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(cur_req, "cyc res_vld", 32'(res_vld), 32'(m_vld));
            chk(cur_req, "cyc status", 32'(res_status), 32'(m_st));
            chk(cur_req, "cyc err_byte", 32'(err_byte), 32'(m_eb));
            chk(cur_req, "cyc err_bit", 32'(err_bit), 32'(m_ebit));
            chk(cur_req, "cyc calc_code", 32'(calc_code), 32'(m_code));
            chk(cur_req, "cyc res_idx", 32'(res_idx), 32'(m_ridx));
            chk(cur_req, "cyc res_ofs", 32'(res_ofs), 32'(8 + 16 * m_ridx));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send(input logic [23:0] stored, input bit same, input bit gaps);
        st_code = stored;
        if (!same) begin
            sec_start = 1; in_vld = 0; step(); sec_start = 0;
        end
        for (int i = 0; i < 512; i++) begin
            if (gaps && (i % 7) == 3) begin
                in_vld = 0; sec_start = 0; step();
            end
            in_vld = 1; in_byte = dbuf[i]; sec_start = same && (i == 0);
            step();
        end
        in_vld = 0; sec_start = 0;
        step();
    endtask

    task automatic check_res(input string req, input logic [23:0] stored);
        int st, eb, ebt;
        logic [23:0] c;
        c = code_of_buf();
        classify(stored, c, st, eb, ebt);
        @(negedge clk);
        chk(req, "res_vld", 32'(res_vld), 32'd1);
        chk(req, "status", 32'(res_status), 32'(st));
        chk(req, "err_byte", 32'(err_byte), 32'(eb));
        chk(req, "err_bit", 32'(err_bit), 32'(ebt));
        chk("R2", "calc_code", 32'(calc_code), 32'(c));
        chk("R9", "res_idx", 32'(res_idx), 32'(exp_idx));
        chk("R9", "res_ofs", 32'(res_ofs), 32'(8 + 16 * exp_idx));
        exp_idx = (exp_idx + 1) % 4;
        #1;
    endtask

    task automatic fill_pattern(input int mul, input int add);
        for (int i = 0; i < 512; i++) dbuf[i] = 8'((i * mul + add) ^ (i >> 3));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [23:0] good;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset res_vld", 32'(res_vld), 32'd0);
        chk("R1", "reset status", 32'(res_status), 32'd0);
        chk("R1", "reset calc_code", 32'(calc_code), 32'd0);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk("R1", "post-reset res_vld", 32'(res_vld), 32'd0);
        chk("R1", "post-reset err_byte", 32'(err_byte), 32'd0);
        cmp_on = 1;
        step();

        // R4: matching code
        cur_req = "R4"; fill_pattern(37, 11); good = code_of_buf();
        send(good, 0, 0); check_res("R4", good);
        chk("R4", "clean status", 32'(res_status), 32'd0);

        // R5: single data bit, middle, then both ends of the sector
        cur_req = "R5"; dbuf[300] ^= 8'h20; send(good, 0, 0); check_res("R5", good);
        chk("R5", "byte 300", 32'(err_byte), 32'd300);
        chk("R5", "bit 5", 32'(err_bit), 32'd5);
        dbuf[300] ^= 8'h20; dbuf[511] ^= 8'h80; send(good, 0, 0); check_res("R5", good);
        chk("R5", "byte 511", 32'(err_byte), 32'd511);
        chk("R5", "bit 7", 32'(err_bit), 32'd7);
        dbuf[511] ^= 8'h80; dbuf[0] ^= 8'h01; send(good, 0, 0); check_res("R5", good);
        chk("R5", "byte 0 status", 32'(res_status), 32'd1);
        chk("R5", "byte 0", 32'(err_byte), 32'd0);
        dbuf[0] ^= 8'h01;

        // R6: one bit of the stored code flipped; index wraps (R9)
        cur_req = "R6"; send(good ^ 24'h004000, 0, 0); check_res("R6", good ^ 24'h004000);
        chk("R6", "code hit", 32'(res_status), 32'd2);
        chk("R9", "wrapped idx", 32'(res_idx), 32'd0);

        // R7: two data bits in one byte
        cur_req = "R7"; dbuf[3] ^= 8'h03; send(good, 0, 0); check_res("R7", good);
        chk("R7", "fatal", 32'(res_status), 32'd3);
        chk("R7", "err_byte zero", 32'(err_byte), 32'd0);
        dbuf[3] ^= 8'h03;

        // R8: erased sector, then all-ones stored code with programmed data
        cur_req = "R8";
        for (int i = 0; i < 512; i++) dbuf[i] = 8'hFF;
        send(24'hFFFFFF, 0, 0); check_res("R8", 24'hFFFFFF);
        chk("R8", "erased clean", 32'(res_status), 32'd0);
        fill_pattern(91, 5); send(24'hFFFFFF, 0, 0); check_res("R8", 24'hFFFFFF);

        // R10 + R12: start rides on first byte, with idle gaps
        cur_req = "R10"; fill_pattern(13, 200); good = code_of_buf();
        send(good, 1, 1); check_res("R10", good);
        chk("R12", "gapped clean", 32'(res_status), 32'd0);

        // R11: surplus bytes leave the result alone
        cur_req = "R11";
        for (int i = 0; i < 20; i++) begin
            in_vld = 1; in_byte = 8'(i * 5 + 1); step();
        end
        in_vld = 0;
        @(negedge clk);
        chk("R11", "held vld", 32'(res_vld), 32'd1);
        chk("R11", "held code", 32'(calc_code), 32'(good));
        chk("R11", "held status", 32'(res_status), 32'd0);

        // R3: start pulse drops the result; abort mid-sector (R10)
        cur_req = "R3";
        @(posedge clk); #1; sec_start = 1; in_vld = 1; in_byte = 8'hA5; step();
        sec_start = 0;
        @(negedge clk);
        chk("R3", "drop after start", 32'(res_vld), 32'd0);
        for (int i = 0; i < 100; i++) begin
            in_byte = 8'(i); step();
        end
        in_vld = 0;
        fill_pattern(7, 3); good = code_of_buf();
        send(good, 0, 0); check_res("R10", good);
        chk("R10", "abort discarded", 32'(res_status), 32'd0);

        cmp_on = 0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule